// File: doc/BRIEF.md
# Flash In-Application Programming Command Mailbox

This block sits on a CPU's special-function-register bus and lets firmware start program, erase and verify operations on an embedded flash array while the program runs. Firmware loads a 16-bit flash address and a data byte into mailbox registers, then writes a command byte. The block decodes the command and checks that programming is enabled and that no other operation is running. It then carries out the command on a small behavioural array model and reports completion.

Program and erase operations hold a busy output for a fixed number of cycles and commit their change to the array on the last busy cycle. The verify operation returns the addressed byte in one cycle. A completion pulse can take over the external interrupt-1 line so that firmware is interrupted when a long operation ends. The configuration register also carries a software reset request and a program-memory bank select.

Register map (SFR address, bit meaning):
- 0xB1 configuration: bit 6 programming enable, bit 1 software reset request, bit 0 bank select; other bits read 0.
- 0xB2 command: bit 7 completion-interrupt enable, bits 6:0 command code.
- 0xB3 / 0xB4 flash address low / high byte.
- 0xB5 data byte.

Command codes:

| Code | Operation |
|------|-----------|
| 0x01 | Chip erase |
| 0x0B | Sector erase |
| 0x0D | Block erase |
| 0x0C | Byte verify |
| 0x0E | Byte program |
| 0x0F | Security bit 0 |
| 0x03 | Security bit 1 |
| 0x05 | Security bit 2 |
| 0x09 | Security bit 3 |
| 0x08 | Clock-doubling flag |

Top module: `iap_mailbox`

## Requirements
- R1: After reset, the registers at 0xB1 to 0xB5 all read 0x00. `flash_busy`, `soft_rst_req`, `bank_sel`, `clk_dbl_en` and `sec_bits` are 0, and every array byte reads 0xFF.
- R2: While bit 6 of 0xB1 is 0, a write to 0xB2 starts no operation, leaves 0xB2 unchanged and does not alter the array.
- R3: A write to 0xB2 with a code outside the command table is ignored. 0xB2 keeps its value, no operation starts, and bit 7 of the written byte has no effect.
- R4: A program-class command (byte program or security bit) raises `flash_busy` from the cycle after the write for PROG_CYCLES cycles. An erase-class command does the same for ERASE_CYCLES cycles. A one-cycle completion event follows in the cycle in which busy is first low.
- R5: Byte program (0x0E) ANDs the 0xB5 value into the byte at the address from 0xB4:0xB3. Byte verify (0x0C) loads that byte into 0xB5 by the next cycle without raising busy.
- R6: While `flash_busy` is 1, a write to 0xB2 is rejected and 0xB2 keeps the running command.
- R7: Each erase command sets bytes to 0xFF over its own scope. Chip erase (0x01) covers the whole array and also clears `sec_bits`. Sector erase (0x0B) covers the 2^SECTOR_W-byte sector containing the address. Block erase (0x0D) covers the half of the array selected by address bit ADDR_W-1.
- R8: When bit 7 of 0xB2 is 1, `irq1_out` carries only the completion event and `ext_irq_in` is ignored. When that bit is 0, `irq1_out` equals `ext_irq_in`.
- R9: Byte verify never produces a completion event on `irq1_out`, even with bit 7 of 0xB2 set.
- R10: Writing 0xB1 with bit 1 set raises `soft_rst_req` for exactly one cycle, after which bit 1 reads 0. Bit 0 of 0xB1 drives `bank_sel`.
- R11: Command 0x08 sets `clk_dbl_en` in the cycle after the write, without raising busy.
- R12: Codes 0x0F, 0x03, 0x05 and 0x09 set `sec_bits` bit 0, 1, 2 and 3 respectively when their program time ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for reads and writes |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational from `sfr_addr`) |
| ext_irq_in | input | 1 | External interrupt-1 pin |
| irq1_out | output | 1 | Interrupt-1 line to the CPU |
| flash_busy | output | 1 | Program or erase in progress |
| soft_rst_req | output | 1 | One-cycle software reset request |
| bank_sel | output | 1 | Program-memory bank select |
| clk_dbl_en | output | 1 | Latched clock-doubling flag |
| sec_bits | output | 4 | Programmed security bits |

## Verification
The assertions assume that `sfr_wr`, `sfr_addr` and `sfr_wdata` are stable around the clock edge and that the write strobe lasts a single cycle per access. They also assume `ext_irq_in` is a synchronous level, so the completion interrupt can be attributed to the cycle after busy. The bench drives every input on the falling edge, pulses the write strobe for exactly one cycle per task, and samples outputs on the falling edge as well. It changes `ext_irq_in` only between accesses, and it keeps both cycle counts at small non-zero values so that busy windows can be counted cycle by cycle.

// File: rtl/iap_pkg.sv
package iap_pkg;

  localparam logic [7:0] SFR_CFG = 8'hB1;
  localparam logic [7:0] SFR_CMD = 8'hB2;
  localparam logic [7:0] SFR_ADL = 8'hB3;
  localparam logic [7:0] SFR_ADH = 8'hB4;
  localparam logic [7:0] SFR_DAT = 8'hB5;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CHIP_ERASE,
    OP_SECTOR_ERASE,
    OP_BLOCK_ERASE,
    OP_VERIFY,
    OP_PROGRAM,
    OP_SEC_BIT,
    OP_CLK_DBL
  } op_e;

  typedef enum logic [1:0] {
    CLS_NONE,
    CLS_INSTANT,
    CLS_PROG,
    CLS_ERASE
  } op_class_e;

  typedef struct packed {
    op_e        op;
    logic [1:0] sec_idx;
  } cmd_dec_t;

  // Map a 7-bit command code to an operation; unknown codes give OP_NONE.
  function automatic cmd_dec_t decode_cmd(input logic [6:0] code);
    cmd_dec_t d;
    d.op      = OP_NONE;
    d.sec_idx = 2'd0;
    case (code)
      7'h01: d.op = OP_CHIP_ERASE;
      7'h0B: d.op = OP_SECTOR_ERASE;
      7'h0D: d.op = OP_BLOCK_ERASE;
      7'h0C: d.op = OP_VERIFY;
      7'h0E: d.op = OP_PROGRAM;
      7'h0F: begin d.op = OP_SEC_BIT; d.sec_idx = 2'd0; end
      7'h03: begin d.op = OP_SEC_BIT; d.sec_idx = 2'd1; end
      7'h05: begin d.op = OP_SEC_BIT; d.sec_idx = 2'd2; end
      7'h09: begin d.op = OP_SEC_BIT; d.sec_idx = 2'd3; end
      7'h08: d.op = OP_CLK_DBL;
      default: d.op = OP_NONE;
    endcase
    return d;
  endfunction

  function automatic logic code_valid(input logic [6:0] code);
    return decode_cmd(code).op != OP_NONE;
  endfunction

  function automatic op_class_e op_class(input op_e op);
    case (op)
      OP_CHIP_ERASE, OP_SECTOR_ERASE, OP_BLOCK_ERASE: return CLS_ERASE;
      OP_PROGRAM, OP_SEC_BIT:                         return CLS_PROG;
      OP_VERIFY, OP_CLK_DBL:                          return CLS_INSTANT;
      default:                                        return CLS_NONE;
    endcase
  endfunction

  // Flash cells can only be pulled from 1 to 0 by programming.
  function automatic logic [7:0] program_byte(input logic [7:0] old_b,
                                              input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Two addresses share a region when they agree above bit 'shift'.
  function automatic logic same_region(input logic [15:0] a,
                                       input logic [15:0] b,
                                       input int unsigned shift);
    return (a >> shift) == (b >> shift);
  endfunction

endpackage

// File: rtl/iap_sfr_regs.sv
module iap_sfr_regs
  import iap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sfr_wr,
  input  logic [7:0]  sfr_addr,
  input  logic [7:0]  sfr_wdata,
  input  logic        cmd_accept,
  input  logic        verify_load,
  input  logic [7:0]  verify_byte,
  output logic        iapen,
  output logic        swr,
  output logic        bsel,
  output logic        fie,
  output logic [6:0]  cmd_code,
  output logic [15:0] flash_addr,
  output logic [7:0]  data_q,
  output logic [7:0]  sfr_rdata
);

  logic [7:0] adl_q, adh_q;
  logic       cfg_wr, adl_wr, adh_wr, dat_wr;

  always_comb begin
    cfg_wr = sfr_wr && (sfr_addr == SFR_CFG);
    adl_wr = sfr_wr && (sfr_addr == SFR_ADL);
    adh_wr = sfr_wr && (sfr_addr == SFR_ADH);
    dat_wr = sfr_wr && (sfr_addr == SFR_DAT);
  end

  // Configuration: the reset-request bit clears itself one cycle after any write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iapen <= 1'b0;
      swr   <= 1'b0;
      bsel  <= 1'b0;
    end else if (cfg_wr) begin
      iapen <= sfr_wdata[6];
      swr   <= sfr_wdata[1];
      bsel  <= sfr_wdata[0];
    end else begin
      swr   <= 1'b0;
    end
  end

  // Command register only changes on an accepted command.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fie      <= 1'b0;
      cmd_code <= 7'd0;
    end else if (cmd_accept) begin
      fie      <= sfr_wdata[7];
      cmd_code <= sfr_wdata[6:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adl_q  <= 8'd0;
      adh_q  <= 8'd0;
      data_q <= 8'd0;
    end else begin
      if (adl_wr)      adl_q  <= sfr_wdata;
      if (adh_wr)      adh_q  <= sfr_wdata;
      if (dat_wr)      data_q <= sfr_wdata;
      if (verify_load) data_q <= verify_byte;
    end
  end

  assign flash_addr = {adh_q, adl_q};

  always_comb begin
    case (sfr_addr)
      SFR_CFG: sfr_rdata = {1'b0, iapen, 4'b0000, swr, bsel};
      SFR_CMD: sfr_rdata = {fie, cmd_code};
      SFR_ADL: sfr_rdata = adl_q;
      SFR_ADH: sfr_rdata = adh_q;
      SFR_DAT: sfr_rdata = data_q;
      default: sfr_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/iap_cmd_gate.sv
module iap_cmd_gate
  import iap_pkg::*;
(
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [6:0] code,
  input  logic       iapen,
  input  logic       busy,
  output logic       cmd_accept,
  output op_e        launch_op,
  output logic [1:0] launch_sec,
  output logic       launch_long,
  output logic       launch_erase,
  output logic       verify_launch,
  output logic       clkdbl_launch
);

  cmd_dec_t  dec;
  op_class_e cls;
  logic      cmd_write;

  always_comb begin
    cmd_write     = sfr_wr && (sfr_addr == SFR_CMD);
    dec           = decode_cmd(code);
    cls           = op_class(dec.op);
    cmd_accept    = cmd_write && iapen && !busy && (dec.op != OP_NONE);
    launch_op     = cmd_accept ? dec.op : OP_NONE;
    launch_sec    = dec.sec_idx;
    launch_long   = cmd_accept && ((cls == CLS_PROG) || (cls == CLS_ERASE));
    launch_erase  = (cls == CLS_ERASE);
    verify_launch = cmd_accept && (dec.op == OP_VERIFY);
    clkdbl_launch = cmd_accept && (dec.op == OP_CLK_DBL);
  end

endmodule

// File: rtl/iap_op_seq.sv
module iap_op_seq
  import iap_pkg::*;
#(
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  logic        launch_erase,
  input  op_e         launch_op,
  input  logic [15:0] launch_addr,
  input  logic [7:0]  launch_data,
  input  logic [1:0]  launch_sec,
  output logic        busy,
  output logic        done,
  output logic        commit,
  output op_e         held_op,
  output logic [15:0] held_addr,
  output logic [7:0]  held_data,
  output logic [1:0]  held_sec
);

  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign commit = busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cnt_q     <= '0;
      held_op   <= OP_NONE;
      held_addr <= 16'd0;
      held_data <= 8'd0;
      held_sec  <= 2'd0;
    end else begin
      done <= commit;
      if (launch) begin
        busy      <= 1'b1;
        cnt_q     <= launch_erase ? ERASE_LOAD : PROG_LOAD;
        held_op   <= launch_op;
        held_addr <= launch_addr;
        held_data <= launch_data;
        held_sec  <= launch_sec;
      end else if (busy) begin
        if (cnt_q == '0) busy <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/iap_flash_array.sv
module iap_flash_array
  import iap_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SECTOR_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        commit,
  input  op_e         op,
  input  logic [15:0] op_addr,
  input  logic [7:0]  op_data,
  input  logic [1:0]  op_sec,
  input  logic [15:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic [3:0]  sec_bits
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic       op_in_range, rd_in_range;

  always_comb begin
    op_in_range = (op_addr >> ADDR_W) == 16'd0;
    rd_in_range = (rd_addr >> ADDR_W) == 16'd0;
    rd_data     = rd_in_range ? mem[rd_addr[ADDR_W-1:0]] : 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      sec_bits <= 4'd0;
    end else if (commit) begin
      case (op)
        OP_CHIP_ERASE: begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
          sec_bits <= 4'd0;
        end
        OP_SECTOR_ERASE: begin
          for (int i = 0; i < DEPTH; i++)
            if (op_in_range && same_region(16'(i), op_addr, SECTOR_W)) mem[i] <= 8'hFF;
        end
        OP_BLOCK_ERASE: begin
          for (int i = 0; i < DEPTH; i++)
            if (op_in_range && same_region(16'(i), op_addr, ADDR_W - 1)) mem[i] <= 8'hFF;
        end
        OP_PROGRAM: begin
          if (op_in_range)
            mem[op_addr[ADDR_W-1:0]] <= program_byte(mem[op_addr[ADDR_W-1:0]], op_data);
        end
        OP_SEC_BIT: sec_bits[op_sec] <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/iap_mailbox.sv
module iap_mailbox
  import iap_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int SECTOR_W     = 4,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sfr_wr,
  input  logic [7:0] sfr_addr,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       ext_irq_in,
  output logic       irq1_out,
  output logic       flash_busy,
  output logic       soft_rst_req,
  output logic       bank_sel,
  output logic       clk_dbl_en,
  output logic [3:0] sec_bits
);

  logic        iapen, swr, fie;
  logic [6:0]  cmd_code;
  logic [15:0] flash_addr;
  logic [7:0]  data_q, rd_byte;
  logic        cmd_accept, launch_long, launch_erase, verify_launch, clkdbl_launch;
  op_e         launch_op;
  logic [1:0]  launch_sec;
  logic        op_done, op_commit;
  op_e         held_op;
  logic [15:0] held_addr;
  logic [7:0]  held_data;
  logic [1:0]  held_sec;
  logic [7:0]  cmd_q;

  assign cmd_q = {fie, cmd_code};

  iap_sfr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .cmd_accept(cmd_accept), .verify_load(verify_launch),
    .verify_byte(rd_byte), .iapen(iapen), .swr(swr), .bsel(bank_sel), .fie(fie),
    .cmd_code(cmd_code), .flash_addr(flash_addr), .data_q(data_q),
    .sfr_rdata(sfr_rdata)
  );

  iap_cmd_gate u_gate (
    .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .code(sfr_wdata[6:0]), .iapen(iapen),
    .busy(flash_busy), .cmd_accept(cmd_accept), .launch_op(launch_op),
    .launch_sec(launch_sec), .launch_long(launch_long), .launch_erase(launch_erase),
    .verify_launch(verify_launch), .clkdbl_launch(clkdbl_launch)
  );

  iap_op_seq #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch_long), .launch_erase(launch_erase),
    .launch_op(launch_op), .launch_addr(flash_addr), .launch_data(data_q),
    .launch_sec(launch_sec), .busy(flash_busy), .done(op_done), .commit(op_commit),
    .held_op(held_op), .held_addr(held_addr), .held_data(held_data),
    .held_sec(held_sec)
  );

  iap_flash_array #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(op_commit), .op(held_op), .op_addr(held_addr),
    .op_data(held_data), .op_sec(held_sec), .rd_addr(flash_addr), .rd_data(rd_byte),
    .sec_bits(sec_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             clk_dbl_en <= 1'b0;
    else if (clkdbl_launch) clk_dbl_en <= 1'b1;
  end

  assign soft_rst_req = swr;
  assign irq1_out     = fie ? op_done : ext_irq_in;

endmodule

// File: rtl/iap_mailbox_chk.sv
module iap_mailbox_chk
  import iap_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sfr_wr,
  input logic [7:0] sfr_addr,
  input logic [7:0] sfr_wdata,
  input logic       iapen,
  input logic [7:0] cmd_q,
  input logic       fie,
  input logic       flash_busy,
  input logic       op_done,
  input logic       verify_launch,
  input logic       irq1_out,
  input logic       soft_rst_req
);

  logic cmd_wr;
  assign cmd_wr = sfr_wr && (sfr_addr == SFR_CMD);

  AST_GATED_BY_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !iapen) |=> ($stable(cmd_q) && !$rose(flash_busy))); // R2

  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !code_valid(sfr_wdata[6:0])) |=> $stable(cmd_q)); // R3

  AST_DONE_ON_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_busy) |-> op_done); // R4

  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && flash_busy) |=> $stable(cmd_q)); // R6

  AST_IRQ_ONLY_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
    (fie && irq1_out) |-> $past(flash_busy)); // R8

  AST_VERIFY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    verify_launch |=> (!flash_busy && !op_done)); // R9

  AST_SWR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req |=> !soft_rst_req); // R10

endmodule

bind iap_mailbox iap_mailbox_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
  .sfr_wdata(sfr_wdata), .iapen(iapen), .cmd_q(cmd_q), .fie(fie),
  .flash_busy(flash_busy), .op_done(op_done), .verify_launch(verify_launch),
  .irq1_out(irq1_out), .soft_rst_req(soft_rst_req)
);

// File: tb/iap_mailbox_tb.sv
module iap_mailbox_tb;

  localparam int PROG_N  = 4;
  localparam int ERASE_N = 12;
  localparam logic [7:0] A_CFG = 8'hB1, A_CMD = 8'hB2, A_ADL = 8'hB3,
                         A_ADH = 8'hB4, A_DAT = 8'hB5;

  logic       clk = 1'b0, rst_n = 1'b0, sfr_wr = 1'b0, ext_irq_in = 1'b0;
  logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
  wire  [7:0] sfr_rdata;
  wire        irq1_out, flash_busy, soft_rst_req, bank_sel, clk_dbl_en;
  wire  [3:0] sec_bits;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  iap_mailbox #(.ADDR_W(8), .SECTOR_W(4), .PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_irq_in(ext_irq_in),
    .irq1_out(irq1_out), .flash_busy(flash_busy), .soft_rst_req(soft_rst_req),
    .bank_sel(bank_sel), .clk_dbl_en(clk_dbl_en), .sec_bits(sec_bits)
  );

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #1;
    d = sfr_rdata;
  endtask

  task automatic set_addr(logic [15:0] a);
    wr(A_ADL, a[7:0]);
    wr(A_ADH, a[15:8]);
  endtask

  task automatic run_cmd(logic [7:0] code, output int cycles);
    wr(A_CMD, code);
    cycles = 0;
    while (flash_busy) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic verify_at(logic [15:0] a, output logic [7:0] d);
    set_addr(a);
    wr(A_CMD, 8'h0C);
    rd(A_DAT, d);
  endtask

  task automatic program_at(logic [15:0] a, logic [7:0] d, output int cycles);
    set_addr(a);
    wr(A_DAT, d);
    run_cmd(8'h0E, cycles);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 'hB1; a <= 'hB5; a++) begin
      rd(8'(a), v);
      check_eq("R1 register reset", v, 0);
    end
    check_eq("R1 busy reset", flash_busy, 0);
    check_eq("R1 reset request idle", soft_rst_req, 0);
    check_eq("R1 outputs reset", {bank_sel, clk_dbl_en, sec_bits}, 0);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    set_addr(16'h0030);
    wr(A_DAT, 8'h00);
    wr(A_CMD, 8'h0E);
    check_eq("R2 no busy when disabled", flash_busy, 0);
    rd(A_CMD, v);
    check_eq("R2 command unchanged when disabled", v, 0);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(A_CMD, 8'h02);
    check_eq("R3 reserved no busy", flash_busy, 0);
    rd(A_CMD, v);
    check_eq("R3 reserved command unchanged", v, 0);
    ext_irq_in = 1'b1;
    wr(A_CMD, 8'h8A);
    rd(A_CMD, v);
    check_eq("R3 reserved with enable bit unchanged", v, 0);
    check_eq("R3 irq still follows pin", irq1_out, 1);
    ext_irq_in = 1'b0;
  endtask

  task automatic t_program();
    int c;
    logic [7:0] v;
    program_at(16'h0012, 8'hA5, c);
    check_eq("R4 program busy cycles", c, PROG_N);
    verify_at(16'h0012, v);
    check_eq("R5 verify after program", v, 8'hA5);
    check_eq("R5 verify no busy", flash_busy, 0);
    verify_at(16'h0030, v);
    check_eq("R2 array untouched while disabled", v, 8'hFF);
    program_at(16'h0012, 8'h3C, c);
    verify_at(16'h0012, v);
    check_eq("R5 program ANDs data", v, 8'h24);
  endtask

  task automatic t_irq_steer();
    int c;
    logic [7:0] v;
    ext_irq_in = 1'b1;
    set_addr(16'h0040);
    wr(A_DAT, 8'h0F);
    wr(A_CMD, 8'h8E);
    c = 0;
    while (flash_busy) begin
      check_eq("R8 pin ignored while busy", irq1_out, 0);
      c++;
      @(negedge clk);
    end
    check_eq("R4 busy cycles with interrupt on", c, PROG_N);
    check_eq("R8 completion pulse", irq1_out, 1);
    @(negedge clk);
    check_eq("R8 pulse is one cycle", irq1_out, 0);
    // Verify with the interrupt enable set: no completion event.
    wr(A_CMD, 8'h8C);
    check_eq("R9 verify no irq", irq1_out, 0);
    check_eq("R9 verify no busy", flash_busy, 0);
    @(negedge clk);
    check_eq("R9 verify no irq later", irq1_out, 0);
    rd(A_DAT, v);
    check_eq("R5 verify loads data", v, 8'h0F);
    wr(A_CMD, 8'h0C);
    check_eq("R8 pin passes when disabled", irq1_out, 1);
    ext_irq_in = 1'b0;
    #1;
    check_eq("R8 pin low passes", irq1_out, 0);
  endtask

  task automatic t_erase();
    int c;
    logic [7:0] v;
    program_at(16'h0022, 8'h00, c);
    set_addr(16'h0015);
    wr(A_CMD, 8'h0B);
    check_eq("R4 erase busy starts", flash_busy, 1);
    wr(A_CMD, 8'h0E);
    rd(A_CMD, v);
    check_eq("R6 command kept while busy", v, 8'h0B);
    while (flash_busy) @(negedge clk);
    verify_at(16'h0012, v);
    check_eq("R7 sector erased", v, 8'hFF);
    verify_at(16'h0022, v);
    check_eq("R7 other sector kept", v, 8'h00);
    program_at(16'h0085, 8'h00, c);
    program_at(16'h0005, 8'h00, c);
    set_addr(16'h0080);
    run_cmd(8'h0D, c);
    check_eq("R4 erase busy cycles", c, ERASE_N);
    verify_at(16'h0085, v);
    check_eq("R7 upper block erased", v, 8'hFF);
    verify_at(16'h0005, v);
    check_eq("R7 lower block kept", v, 8'h00);
  endtask

  task automatic t_sec_and_chip();
    int c;
    logic [7:0] v;
    run_cmd(8'h03, c);
    check_eq("R12 security bit 1", sec_bits, 4'b0010);
    run_cmd(8'h09, c);
    check_eq("R12 security bit 3", sec_bits, 4'b1010);
    check_eq("R4 security program cycles", c, PROG_N);
    run_cmd(8'h0F, c);
    run_cmd(8'h05, c);
    check_eq("R12 all security bits", sec_bits, 4'b1111);
    wr(A_CMD, 8'h08);
    check_eq("R11 clock doubling flag", clk_dbl_en, 1);
    check_eq("R11 clock doubling no busy", flash_busy, 0);
    run_cmd(8'h01, c);
    check_eq("R7 chip erase cycles", c, ERASE_N);
    verify_at(16'h0005, v);
    check_eq("R7 chip erase byte", v, 8'hFF);
    verify_at(16'h0022, v);
    check_eq("R7 chip erase byte 2", v, 8'hFF);
    check_eq("R7 chip erase clears security", sec_bits, 0);
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    wr(A_CFG, 8'h43);
    check_eq("R10 reset request high", soft_rst_req, 1);
    check_eq("R10 bank select", bank_sel, 1);
    @(negedge clk);
    check_eq("R10 reset request one cycle", soft_rst_req, 0);
    rd(A_CFG, v);
    check_eq("R10 reset bit self-clears", v, 8'h41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    wr(A_CFG, 8'h40);
    t_reserved();
    t_program();
    t_irq_steer();
    t_erase();
    t_sec_and_chip();
    t_soft_reset();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule